// File: doc/BRIEF.md
# Infrared Link Interrupt Status Controller

This block gathers single-cycle event pulses from an infrared serial link controller and turns them into one interrupt line. The block also exposes them as registers on a simple 16-bit register bus. It keeps two banks of sticky status, per-bit mask and write-one-to-clear registers. One bank serves the slow asynchronous mode. The other serves the two fast synchronous modes. A transfer-mode register holds a two-bit mode selector and three top-level mask bits.

Five event pulses enter on `ev_pulse`. The current mode decides which bank records them. Two of the event lines carry a different meaning in each mode. Index 2 (status bit 9) is a receive timeout in the slow mode and an abort detection in the fast modes. Index 1 (status bit 8) is a framing error in the slow mode and a CRC error in the fast modes. The interrupt output combines the pending, unmasked status bits of the bank that the mode selects, gated by that bank's top-level mask. Reads are combinational from the bus address. Writes take effect on the rising clock edge.

Top module: `ir_irq_ctrl`

## Requirements
- R1: After reset, both status registers read 0x0000, both mask registers read 0x8B80 (all five status bits masked), the mode register reads 0x0111 (slow mode with all three top-level masks set), and `irq_o` is 0.
- R2: In mode 00 (slow), a pulse on `ev_pulse[i]` sets the status bit of the slow bank one edge later. The mapping is index 0 to bit 7 (transmit end), 1 to bit 8, 2 to bit 9, 3 to bit 11 (overflow) and 4 to bit 15 (receive end). A set bit stays set until it is cleared.
- R3: In mode 11 or 10 (fast), events set the fast bank with the same bit mapping. In mode 01 (reserved), events are dropped and neither bank changes.
- R4: A write to a clear register (slow at address 3, fast at address 6) clears each status bit whose data bit is 1 and leaves the other bits alone. An event and a clear of the same bit in the same cycle leave the bit set. Clear registers read 0x0000.
- R5: Writes to the status registers (slow at address 1, fast at address 4) have no effect.
- R6: The mask registers (slow at address 2, fast at address 5) store only bits 15, 11, 9, 8 and 7. All other bits read 0. A 1 blocks that source from the interrupt.
- R7: The mode register (address 0) stores the mode in bits 15:14 and the top-level masks in bits 8 (FIFO receive), 4 (fast bank) and 0 (slow bank). Its other bits read 0. Address 7 reads 0, and writes to it are ignored.
- R8: `irq_o` follows the register state with no added latency. In mode 00 it is the OR of the slow status bits that are set and unmasked, forced to 0 while bit 0 of the mode register is 1. In modes 11 and 10 it is the same function of the fast bank, gated by bit 4. In mode 01 it is 0. Bit 8 of the mode register never affects `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse | input | 5 | Event pulses: 0 transmit end, 1 framing/CRC error, 2 timeout/abort, 3 overflow, 4 receive end |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` while `bus_sel` is 1, else 0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is a known value once reset has been released. They also assume that a write is qualified by `bus_sel` and `bus_wr` alone, so the registered bank state can be judged against the address and data seen in the previous cycle. The bench meets both assumptions by driving every input only on the falling edge and by parking the bus in a read with no events between operations. Random operations cover all eight addresses with unrestricted data, including unmapped address 7 and the reserved mode 01. Directed steps fix the event-versus-clear collision and the top-level mask cases.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   localparam int NEV = 5;
   localparam int REG_W_MIN = 16;

   typedef enum logic [1:0] {
      MODE_SLOW = 2'b00,
      MODE_RSVD = 2'b01,
      MODE_TOP  = 2'b10,
      MODE_MID  = 2'b11
   } xfer_mode_e;

   localparam int MODE_LSB  = 14;
   localparam int TOPM_FIFO = 8;
   localparam int TOPM_FAST = 4;
   localparam int TOPM_SLOW = 0;

   localparam logic [15:0] MODE_KEEP   = 16'hC111;
   localparam logic [15:0] MODE_RESET  = 16'h0111;

   // status bit position of each event index
   function automatic int ev_pos(int i);
      case (i)
         0:       return 7;
         1:       return 8;
         2:       return 9;
         3:       return 11;
         default: return 15;
      endcase
   endfunction

   // event index owning a status bit, -1 if the bit is unused
   function automatic int ev_idx(int b);
      for (int i = 0; i < NEV; i++)
         if (ev_pos(i) == b) return i;
      return -1;
   endfunction

   function automatic logic [15:0] ev_spread(logic [NEV-1:0] ev);
      logic [15:0] r;
      r = '0;
      for (int i = 0; i < NEV; i++) r[ev_pos(i)] = ev[i];
      return r;
   endfunction

endpackage

// File: rtl/irqc_group.sv
module irqc_group
   import irqc_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NEV-1:0]    ev_in,
   input  logic              mask_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] stat_q,
   output logic [DATA_W-1:0] mask_q,
   output logic              pend
);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam int IDX = ev_idx(b);
      if (IDX >= 0) begin : g_live
         logic s_r, m_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_r <= 1'b0;
               m_r <= 1'b1;
            end else begin
               if (ev_in[IDX])
                  s_r <= 1'b1;
               else if (clr_we && wdata[b])
                  s_r <= 1'b0;
               if (mask_we)
                  m_r <= wdata[b];
            end
         end
         assign stat_q[b] = s_r;
         assign mask_q[b] = m_r;
      end else begin : g_tie
         assign stat_q[b] = 1'b0;
         assign mask_q[b] = 1'b0;
      end
   end

   assign pend = |(stat_q & ~mask_q);

   logic unused_wbits;
   assign unused_wbits = ^wdata;

endmodule

// File: rtl/irqc_mode_reg.sv
module irqc_mode_reg
   import irqc_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output xfer_mode_e        mode_q,
   output logic              top_fifo_q,
   output logic              top_fast_q,
   output logic              top_slow_q,
   output logic [DATA_W-1:0] rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MODE_SLOW;
         top_fifo_q <= MODE_RESET[TOPM_FIFO];
         top_fast_q <= MODE_RESET[TOPM_FAST];
         top_slow_q <= MODE_RESET[TOPM_SLOW];
      end else if (we) begin
         mode_q     <= xfer_mode_e'(wdata[MODE_LSB+1:MODE_LSB]);
         top_fifo_q <= wdata[TOPM_FIFO];
         top_fast_q <= wdata[TOPM_FAST];
         top_slow_q <= wdata[TOPM_SLOW];
      end
   end

   always_comb begin
      rdata = '0;
      rdata[MODE_LSB+1:MODE_LSB] = mode_q;
      rdata[TOPM_FIFO] = top_fifo_q;
      rdata[TOPM_FAST] = top_fast_q;
      rdata[TOPM_SLOW] = top_slow_q;
   end

   logic unused_wbits;
   assign unused_wbits = ^wdata;

endmodule

// File: rtl/irqc_gate.sv
module irqc_gate
   import irqc_pkg::*;
(
   input  xfer_mode_e     mode,
   input  logic [NEV-1:0] ev,
   input  logic           top_slow,
   input  logic           top_fast,
   input  logic           pend_slow,
   input  logic           pend_fast,
   output logic [NEV-1:0] ev_slow,
   output logic [NEV-1:0] ev_fast,
   output logic           irq
);

   always_comb begin
      ev_slow = '0;
      ev_fast = '0;
      irq     = 1'b0;
      case (mode)
         MODE_SLOW: begin
            ev_slow = ev;
            irq     = pend_slow & ~top_slow;
         end
         MODE_MID, MODE_TOP: begin
            ev_fast = ev;
            irq     = pend_fast & ~top_fast;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/ir_irq_ctrl.sv
module ir_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 3,
   parameter int A_MODE  = 0,
   parameter int A_SSTAT = 1,
   parameter int A_SMASK = 2,
   parameter int A_SCLR  = 3,
   parameter int A_FSTAT = 4,
   parameter int A_FMASK = 5,
   parameter int A_FCLR  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NEV-1:0]    ev_pulse,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   localparam int NADDR = 2 ** ADDR_W;
   localparam int NGRP  = 2;

   if (DATA_W < REG_W_MIN) begin : g_chk_w
      $error("ir_irq_ctrl: DATA_W below 16 cannot hold status bit 15");
   end
   if (A_MODE >= NADDR || A_SSTAT >= NADDR || A_SMASK >= NADDR || A_SCLR >= NADDR ||
       A_FSTAT >= NADDR || A_FMASK >= NADDR || A_FCLR >= NADDR) begin : g_chk_a
      $error("ir_irq_ctrl: register address outside ADDR_W range");
   end

   logic wr_en;
   assign wr_en = bus_sel & bus_wr;

   xfer_mode_e        mode_q;
   logic              top_fifo_q, top_fast_q, top_slow_q;
   logic [DATA_W-1:0] mode_rd;

   irqc_mode_reg #(.DATA_W(DATA_W)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (wr_en && bus_addr == ADDR_W'(A_MODE)),
      .wdata      (bus_wdata),
      .mode_q     (mode_q),
      .top_fifo_q (top_fifo_q),
      .top_fast_q (top_fast_q),
      .top_slow_q (top_slow_q),
      .rdata      (mode_rd)
   );

   logic [NEV-1:0] ev_slow, ev_fast;
   logic [NGRP-1:0][DATA_W-1:0] grp_stat, grp_mask;
   logic [NGRP-1:0] grp_pend;

   irqc_gate u_gate (
      .mode      (mode_q),
      .ev        (ev_pulse),
      .top_slow  (top_slow_q),
      .top_fast  (top_fast_q),
      .pend_slow (grp_pend[0]),
      .pend_fast (grp_pend[1]),
      .ev_slow   (ev_slow),
      .ev_fast   (ev_fast),
      .irq       (irq_o)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int AM = (g == 0) ? A_SMASK : A_FMASK;
      localparam int AC = (g == 0) ? A_SCLR  : A_FCLR;
      irqc_group #(.DATA_W(DATA_W)) u_grp (
         .clk     (clk),
         .rst_n   (rst_n),
         .ev_in   ((g == 0) ? ev_slow : ev_fast),
         .mask_we (wr_en && bus_addr == ADDR_W'(AM)),
         .clr_we  (wr_en && bus_addr == ADDR_W'(AC)),
         .wdata   (bus_wdata),
         .stat_q  (grp_stat[g]),
         .mask_q  (grp_mask[g]),
         .pend    (grp_pend[g])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         if (bus_addr == ADDR_W'(A_MODE))       bus_rdata = mode_rd;
         else if (bus_addr == ADDR_W'(A_SSTAT)) bus_rdata = grp_stat[0];
         else if (bus_addr == ADDR_W'(A_SMASK)) bus_rdata = grp_mask[0];
         else if (bus_addr == ADDR_W'(A_FSTAT)) bus_rdata = grp_stat[1];
         else if (bus_addr == ADDR_W'(A_FMASK)) bus_rdata = grp_mask[1];
      end
   end

   logic unused_fifo;
   assign unused_fifo = top_fifo_q;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
   import irqc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3,
   parameter int A_SCLR = 3,
   parameter int A_FCLR = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NEV-1:0]    ev_pulse,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq_o,
   input logic [1:0]        mode,
   input logic              top_slow,
   input logic              top_fast,
   input logic [DATA_W-1:0] stat_slow,
   input logic [DATA_W-1:0] stat_fast,
   input logic [DATA_W-1:0] mask_slow,
   input logic [DATA_W-1:0] mask_fast
);

   logic clr_s, clr_f;
   assign clr_s = bus_sel && bus_wr && bus_addr == ADDR_W'(A_SCLR);
   assign clr_f = bus_sel && bus_wr && bus_addr == ADDR_W'(A_FCLR);

   // R2: status bits only fall through a clear write
   a_r2_sticky_slow: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_s |=> ((stat_slow & $past(stat_slow)) == $past(stat_slow)));
   a_r2_sticky_fast: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_f |=> ((stat_fast & $past(stat_fast)) == $past(stat_fast)));

   // R2 / R4: an event in slow mode lands even against a clear
   a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |=>
      ((stat_slow[15:0] & ev_spread($past(ev_pulse))) == ev_spread($past(ev_pulse))));

   // R4: clear in a mode that routes nothing to the slow bank empties the written bits
   a_r4_clear_slow: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_s && mode != 2'b00) |=> ((stat_slow & $past(bus_wdata)) == '0));

   // R3: fast modes route events to the fast bank
   a_r3_fast_route: assert property (@(posedge clk) disable iff (!rst_n)
      mode[1] |=>
      ((stat_fast[15:0] & ev_spread($past(ev_pulse))) == ev_spread($past(ev_pulse))));

   // R3: reserved mode gains no bits in either bank
   a_r3_rsvd_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |=>
      ((stat_slow & ~$past(stat_slow)) == '0 && (stat_fast & ~$past(stat_fast)) == '0));

   // R8: interrupt gating
   a_r8_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b01) |-> !irq_o);
   a_r8_slow_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && top_slow) |-> !irq_o);
   a_r8_slow_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !top_slow && |(stat_slow & ~mask_slow)) |-> irq_o);
   a_r8_fast_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[1] && !top_fast && |(stat_fast & ~mask_fast)) |-> irq_o);

endmodule

bind ir_irq_ctrl irqc_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .A_SCLR (A_SCLR),
   .A_FCLR (A_FCLR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_pulse  (ev_pulse),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq_o     (irq_o),
   .mode      (mode_q),
   .top_slow  (top_slow_q),
   .top_fast  (top_fast_q),
   .stat_slow (grp_stat[0]),
   .stat_fast (grp_stat[1]),
   .mask_slow (grp_mask[0]),
   .mask_fast (grp_mask[1])
);

// File: tb/tb_ir_irq_ctrl.sv
`timescale 1ns/100ps
module tb_ir_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  ev_pulse;
   logic        bus_sel, bus_wr;
   logic [2:0]  bus_addr;
   logic [15:0] bus_wdata;
   logic [15:0] bus_rdata;
   logic        irq_o;

   always #5 clk = ~clk;

   ir_irq_ctrl dut (
      .clk (clk), .rst_n (rst_n), .ev_pulse (ev_pulse),
      .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq_o (irq_o)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model, built from the requirements
   logic [15:0] m_mode, m_ss, m_sm, m_fs, m_fm;
   localparam logic [15:0] VALID = 16'h8B80;

   function automatic logic [15:0] spread(logic [4:0] ev);
      logic [15:0] r = '0;
      r[7] = ev[0]; r[8] = ev[1]; r[9] = ev[2]; r[11] = ev[3]; r[15] = ev[4];
      return r;
   endfunction

   function automatic logic exp_irq();
      case (m_mode[15:14])
         2'b00:        return (|(m_ss & ~m_sm)) & ~m_mode[0];
         2'b10, 2'b11: return (|(m_fs & ~m_fm)) & ~m_mode[4];
         default:      return 1'b0;
      endcase
   endfunction

   function automatic logic [15:0] exp_read(int a);
      case (a)
         0: return m_mode;
         1: return m_ss;
         2: return m_sm;
         4: return m_fs;
         5: return m_fm;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic model_reset();
      m_mode = 16'h0111; m_ss = '0; m_fs = '0; m_sm = VALID; m_fm = VALID;
   endtask

   task automatic model_step(logic [4:0] ev, logic wr, int a, logic [15:0] d);
      logic [15:0] evs, evf, ns, nf;
      evs = (m_mode[15:14] == 2'b00) ? spread(ev) : 16'h0;
      evf = m_mode[15] ? spread(ev) : 16'h0;
      ns = m_ss; nf = m_fs;
      if (wr && a == 3) ns = ns & ~d;
      if (wr && a == 6) nf = nf & ~d;
      m_ss = ns | evs;
      m_fs = nf | evf;
      if (wr && a == 2) m_sm = d & VALID;
      if (wr && a == 5) m_fm = d & VALID;
      if (wr && a == 0) m_mode = d & 16'hC111;
   endtask

   task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one edge with the given inputs; model follows
   task automatic step(logic [4:0] ev, logic wr, int a, logic [15:0] d);
      @(negedge clk);
      ev_pulse = ev; bus_sel = wr; bus_wr = wr; bus_addr = 3'(a); bus_wdata = d;
      model_step(ev, wr, a, d);
      @(posedge clk);
   endtask

   // read back every address and the interrupt, away from the edge
   task automatic check_all(string tag);
      @(negedge clk);
      ev_pulse = '0; bus_wr = 1'b0; bus_sel = 1'b1; bus_wdata = '0;
      for (int a = 0; a < 8; a++) begin
         bus_addr = 3'(a);
         #0.4;
         check(tag, $sformatf("addr %0d", a), bus_rdata, exp_read(a));
      end
      check(tag, "irq_o", {15'h0, irq_o}, {15'h0, exp_irq()});
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; ev_pulse = '0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
      model_reset();
      repeat (3) @(posedge clk);
      check_all("R1");                          // R1 during reset
      @(negedge clk) rst_n = 1'b1;
      check_all("R1");

      // R6, R7: only defined bits stored
      step('0, 1, 2, 16'hFFFF); check_all("R6");
      step('0, 1, 0, 16'hFFFF); check_all("R7");
      step('0, 1, 7, 16'hFFFF); check_all("R7");   // unmapped address
      // slow mode, open everything
      step('0, 1, 0, 16'h0000);
      step('0, 1, 2, 16'h0000);
      step(5'b00001, 0, 0, '0); check_all("R2");   // bit 7 set, irq rises (R8)
      step('0, 0, 0, '0);       check_all("R2");   // sticky
      step('0, 1, 1, 16'hFFFF); check_all("R5");   // status write ignored
      step(5'b00001, 1, 3, 16'h0080); check_all("R4"); // event beats clear
      step(5'b11110, 0, 0, '0); check_all("R2");
      step('0, 1, 3, 16'h0880); check_all("R4");   // partial clear
      step('0, 1, 0, 16'h0001); check_all("R8");   // slow top mask blocks
      // reserved mode drops events
      step('0, 1, 0, 16'h4000);
      step(5'b11111, 0, 0, '0); check_all("R3");
      // fast middle rate
      step('0, 1, 0, 16'hC000);
      step('0, 1, 5, 16'h0000);
      step(5'b10000, 0, 0, '0); check_all("R3");
      step('0, 1, 0, 16'hC100); check_all("R8");   // FIFO top mask has no effect
      step('0, 1, 0, 16'hC110); check_all("R8");   // fast top mask blocks
      step('0, 1, 0, 16'h8000);
      step(5'b00100, 1, 6, 16'h8200); check_all("R4");
      step('0, 1, 4, 16'h0000); check_all("R5");

      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         logic [4:0]  ev;
         logic        wr;
         int          a;
         logic [15:0] d;
         ev = ($urandom % 3 == 0) ? 5'($urandom) : 5'h0;
         wr = ($urandom % 4 != 0);
         a  = $urandom % 8;
         d  = 16'($urandom);
         if (a == 0 && ($urandom % 2 == 0)) d = d & 16'hC000;  // favour open top masks
         if (a == 2 || a == 5) d = d & 16'($urandom);
         step(ev, wr, a, d);
         check_all("R8");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule